// File: doc/BRIEF.md
# Instruction Prefetch Buffer with Snoop

This block sits next to an instruction cache and handles the fetches that the cache cannot serve: cacheable fetches that missed the cache, and non-cacheable fetches. On a miss it issues one bus read that is twice the length of a cache line. The bus returns it as four 8-byte beats. The first two beats form the requested 16-byte line, which is returned to the fetcher and, for cacheable fetches, sent to the cache on the fill port. The last two beats are kept as a single prefetched block for the next sequential line.

A later fetch that hits the held block is answered one cycle later with no bus traffic. A cacheable hit also moves the block to the fill port and empties the buffer. A non-cacheable hit leaves the block in place, so it can keep serving non-cacheable fetches. If a fetch arrives while the prefetched beats are still on the bus, it waits for the burst to end. It is then either served from the fresh block or starts a new burst.

Snoop addresses arrive from two sources: data-side read/write misses and external inquire cycles. Either source invalidates the held block when the snoop address falls within it. This includes a block that is still arriving on the bus, whose remaining beats are then discarded.

Top module: `ipf_buffer`

## Requirements
- R1: After reset, fetch_valid, fill_valid and bus_req are low and no block is held, so the first fetch always goes to the bus.
- R2: A fetch that misses raises bus_req for exactly one cycle, in the cycle after the request. bus_addr is the fetch address with its low 4 bits cleared. The bus then returns four 8-byte beats in ascending address order.
- R3: On a miss, fetch_valid rises in the cycle after the second beat is accepted. fetch_data[63:0] holds the first beat and fetch_data[127:64] holds the second beat. Idle cycles between beats delay the response by the same number of cycles.
- R4: A fill is sent only alongside a response, and only for a cacheable fetch (fetch_cacheable = 1). fill_addr is the 16-byte-aligned line address, and fill_data equals the returned line. A non-cacheable fetch produces no fill.
- R5: The third and fourth beats of a burst become the held block for the line 16 bytes above the missed line. The block is valid once the fourth beat is accepted.
- R6: A fetch whose line matches a valid held block gets fetch_valid in the next cycle and issues no bus request.
- R7: A cacheable hit sends the block on the fill port in the same cycle as the response, and the buffer is empty afterwards.
- R8: A non-cacheable hit produces no fill, and the block stays valid for later fetches.
- R9: A snoop with snoop_src = 0 (data-side miss) or snoop_src = 1 (inquire cycle) whose address lies in the held block makes it invalid from the next cycle.
- R10: A snoop whose address lies outside the held block leaves the block valid.
- R11: A snoop that targets the block still arriving on the bus causes its remaining beats to be discarded. This also applies when the snoop lands in the same cycle as the last beat. The buffer stays invalid after the burst.
- R12: A fetch issued while the prefetched beats are still arriving waits for the last beat. It is answered in the cycle after that beat if it targets the new valid block; otherwise a new bus request is issued in that cycle.
- R13: When a fetch and a snoop to the same held block arrive in the same cycle, the snoop wins and the fetch is handled as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | One-cycle fetch request; at most one outstanding |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_cacheable | input | 1 | 1 when the fetched line may be placed in the cache |
| fetch_valid | output | 1 | Fetch response strobe |
| fetch_data | output | 128 | Fetched 16-byte line, lowest address in the low bits |
| fill_valid | output | 1 | Line fill strobe toward the instruction cache |
| fill_addr | output | 32 | Line-aligned fill address |
| fill_data | output | 128 | Fill line data |
| bus_req | output | 1 | One-cycle burst read request |
| bus_addr | output | 32 | Burst start address, line aligned |
| bus_beat_valid | input | 1 | Return beat strobe |
| bus_beat_data | input | 64 | Return beat data |
| snoop_valid | input | 1 | Snoop address strobe |
| snoop_addr | input | 32 | Snooped byte address |
| snoop_src | input | 1 | 0 = data-side miss, 1 = external inquire |

## Verification
Two functions can fall in the same cycle, and both overlaps are exercised.

The first is a fetch hit together with a snoop invalidation. The bench drives a fetch and a snoop to the same valid block in the same cycle and expects a bus burst and the three-cycle miss latency instead of a one-cycle hit.

The second is the end of a burst together with a snoop or a waiting fetch. A snoop is placed exactly in the cycle of the fourth beat, and in a separate case a waiting fetch meets a snoop to its own target. The bench judges both by whether the next access to that block goes to the bus, and by the exact response latency.

// File: rtl/ipf_pkg.sv
`timescale 1ns/1ps
package ipf_pkg;
    localparam int ADDR_W         = 32;
    localparam int LINE_BYTES     = 16;
    localparam int BEAT_BYTES     = 8;
    localparam logic [1:0] SNOOP_SRC_EN = 2'b11;

    localparam int LINE_OFF       = $clog2(LINE_BYTES);
    localparam int TAG_W          = ADDR_W - LINE_OFF;
    localparam int BEAT_W         = BEAT_BYTES * 8;
    localparam int LINE_W         = LINE_BYTES * 8;
    localparam int BEATS_PER_LINE = LINE_BYTES / BEAT_BYTES;
    localparam int BURST_BEATS    = 2 * BEATS_PER_LINE;
    localparam int CNT_W          = $clog2(BURST_BEATS);
    localparam int SLOT_W         = $clog2(BEATS_PER_LINE);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [BEAT_W-1:0] beat_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic {ST_IDLE, ST_BURST} ipf_state_e;

    typedef struct packed {
        logic  vld;
        tag_t  tag;
        line_t data;
    } pblock_t;

    typedef struct packed {
        logic cache;
        tag_t tag;
    } freq_t;

    function automatic tag_t line_of(addr_t a);
        return a[ADDR_W-1:LINE_OFF];
    endfunction

    function automatic addr_t addr_of(tag_t t);
        return {t, {LINE_OFF{1'b0}}};
    endfunction
endpackage

// File: rtl/ipf_tag_cmp.sv
`timescale 1ns/1ps
module ipf_tag_cmp
    import ipf_pkg::*;
(
    input  logic en,
    input  tag_t a,
    input  tag_t b,
    output logic hit
);
    assign hit = en && (a == b);
endmodule

// File: rtl/ipf_beat_asm.sv
`timescale 1ns/1ps
module ipf_beat_asm
    import ipf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_vld,
    input  logic [SLOT_W-1:0] slot_idx,
    input  beat_t             beat_data,
    output line_t             line_out
);
    for (genvar j = 0; j < BEATS_PER_LINE - 1; j++) begin : g_slot
        beat_t slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (beat_vld && slot_idx == SLOT_W'(j))
                slot_q <= beat_data;
        end
        assign line_out[j*BEAT_W +: BEAT_W] = slot_q;
    end
    assign line_out[LINE_W-1 -: BEAT_W] = beat_data;
endmodule

// File: rtl/ipf_buffer.sv
`timescale 1ns/1ps
module ipf_buffer
    import ipf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_cacheable,
    output logic              fetch_valid,
    output logic [LINE_W-1:0] fetch_data,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [LINE_W-1:0] fill_data,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_beat_valid,
    input  logic [BEAT_W-1:0] bus_beat_data,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              snoop_src
);
    ipf_state_e       st;
    logic [CNT_W-1:0] beat_cnt;
    tag_t             burst_tag;
    logic             burst_cache;
    logic             kill;
    logic             pend_vld;
    freq_t            pend;
    pblock_t          pb;

    logic  beat_in, last_slot, second_half, line_done, burst_end;
    logic  snoop_act, take, go, cur_vld, eff_vld;
    logic  snp_cur, snp_new, snp_flight, req_hit;
    tag_t  next_tag, cur_tag, snoop_line, new_next;
    line_t cur_data, asm_line;
    freq_t req;
    logic  pf_vld;
    tag_t  pf_tag;
    logic  unused_low;

    assign unused_low  = ^{fetch_addr[LINE_OFF-1:0], snoop_addr[LINE_OFF-1:0]};
    assign snoop_act   = snoop_valid && SNOOP_SRC_EN[snoop_src];
    assign snoop_line  = line_of(snoop_addr);

    assign beat_in     = (st == ST_BURST) && bus_beat_valid;
    assign last_slot   = beat_cnt[SLOT_W-1:0] == SLOT_W'(BEATS_PER_LINE - 1);
    assign second_half = beat_cnt[CNT_W-1];
    assign line_done   = beat_in && last_slot && !second_half;
    assign burst_end   = beat_in && last_slot && second_half;
    assign next_tag    = burst_tag + tag_t'(1);

    // View of the block as it stands this cycle (fresh block on the last beat)
    assign cur_vld  = burst_end ? !kill    : pb.vld;
    assign cur_tag  = burst_end ? next_tag : pb.tag;
    assign cur_data = burst_end ? asm_line : pb.data;
    assign eff_vld  = cur_vld && !snp_cur;

    assign take     = (st == ST_IDLE) || burst_end;
    assign go       = take && (pend_vld || fetch_req);
    assign req      = pend_vld ? pend : '{cache: fetch_cacheable, tag: line_of(fetch_addr)};
    assign new_next = req.tag + tag_t'(1);

    assign pf_vld = pb.vld;
    assign pf_tag = pb.tag;

    ipf_beat_asm u_asm (
        .clk      (clk),
        .rst      (rst),
        .beat_vld (beat_in),
        .slot_idx (beat_cnt[SLOT_W-1:0]),
        .beat_data(bus_beat_data),
        .line_out (asm_line)
    );

    ipf_tag_cmp u_cmp_snp_cur (.en(snoop_act), .a(snoop_line), .b(cur_tag),  .hit(snp_cur));
    ipf_tag_cmp u_cmp_snp_new (.en(snoop_act), .a(snoop_line), .b(new_next), .hit(snp_new));
    ipf_tag_cmp u_cmp_snp_fly (.en(snoop_act), .a(snoop_line), .b(next_tag), .hit(snp_flight));
    ipf_tag_cmp u_cmp_req     (.en(eff_vld),   .a(req.tag),    .b(cur_tag),  .hit(req_hit));

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            beat_cnt    <= '0;
            burst_tag   <= '0;
            burst_cache <= 1'b0;
            kill        <= 1'b0;
            pend_vld    <= 1'b0;
            pend        <= '0;
            pb          <= '0;
            fetch_valid <= 1'b0;
            fetch_data  <= '0;
            fill_valid  <= 1'b0;
            fill_addr   <= '0;
            fill_data   <= '0;
            bus_req     <= 1'b0;
            bus_addr    <= '0;
        end else begin
            fetch_valid <= 1'b0;
            fill_valid  <= 1'b0;
            bus_req     <= 1'b0;
            if (beat_in)
                beat_cnt <= beat_cnt + CNT_W'(1);

            if (!take) begin
                kill <= kill | snp_flight;
                if (fetch_req) begin
                    pend_vld <= 1'b1;
                    pend     <= '{cache: fetch_cacheable, tag: line_of(fetch_addr)};
                end
                if (line_done) begin
                    fetch_valid <= 1'b1;
                    fetch_data  <= asm_line;
                    fill_valid  <= burst_cache;
                    fill_addr   <= addr_of(burst_tag);
                    fill_data   <= asm_line;
                end
            end else begin
                st       <= ST_IDLE;
                pend_vld <= 1'b0;
                pb       <= '{vld: eff_vld, tag: cur_tag, data: cur_data};
                if (go) begin
                    if (req_hit) begin
                        fetch_valid <= 1'b1;
                        fetch_data  <= cur_data;
                        if (req.cache) begin
                            fill_valid <= 1'b1;
                            fill_addr  <= addr_of(cur_tag);
                            fill_data  <= cur_data;
                            pb.vld     <= 1'b0;
                        end
                    end else begin
                        bus_req     <= 1'b1;
                        bus_addr    <= addr_of(req.tag);
                        st          <= ST_BURST;
                        burst_tag   <= req.tag;
                        burst_cache <= req.cache;
                        beat_cnt    <= '0;
                        kill        <= snp_new;
                        pb.vld      <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ipf_buffer_chk.sv
`timescale 1ns/1ps
module ipf_buffer_chk
    import ipf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fetch_valid,
    input logic              fill_valid,
    input logic              bus_req,
    input logic              snoop_valid,
    input logic              snoop_src,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic              pf_vld,
    input tag_t              pf_tag,
    input logic              kill,
    input logic              burst_end
);
    AST_BUS_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> !bus_req); // R2

    AST_FILL_WITH_RESP: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> fetch_valid); // R4

    AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> !bus_req); // R6

    AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && SNOOP_SRC_EN[snoop_src] && pf_vld && line_of(snoop_addr) == pf_tag)
        |=> !pf_vld); // R9

    AST_KILL_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (burst_end && kill) |=> !pf_vld); // R11
endmodule

bind ipf_buffer ipf_buffer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fetch_valid(fetch_valid),
    .fill_valid (fill_valid),
    .bus_req    (bus_req),
    .snoop_valid(snoop_valid),
    .snoop_src  (snoop_src),
    .snoop_addr (snoop_addr),
    .pf_vld     (pf_vld),
    .pf_tag     (pf_tag),
    .kill       (kill),
    .burst_end  (burst_end)
);

// File: tb/ipf_buffer_bench.sv
`timescale 1ns/1ps
module ipf_buffer_bench;
    import ipf_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              fetch_req = 1'b0;
    logic [ADDR_W-1:0] fetch_addr = '0;
    logic              fetch_cacheable = 1'b0;
    logic              fetch_valid;
    logic [LINE_W-1:0] fetch_data;
    logic              fill_valid;
    logic [ADDR_W-1:0] fill_addr;
    logic [LINE_W-1:0] fill_data;
    logic              bus_req;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_beat_valid = 1'b0;
    logic [BEAT_W-1:0] bus_beat_data = '0;
    logic              snoop_valid = 1'b0;
    logic [ADDR_W-1:0] snoop_addr = '0;
    logic              snoop_src = 1'b0;

    int checks = 0, errors = 0;
    int cyc = 0, gap = 0;
    int resp_cnt = 0, resp_time = 0, bus_cnt = 0, fill_cnt = 0;
    int t_issue = 0, b_issue = 0, r_issue = 0, f_issue = 0;
    logic              outstanding = 1'b0;
    logic [ADDR_W-1:0] out_addr = '0;
    logic              out_cache = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ipf_buffer u_ipf_buffer (.*);

    function automatic beat_t mem_beat(logic [ADDR_W-1:0] a);
        return {a ^ 32'h5A5A_C3C3, a};
    endfunction

    function automatic line_t mem_line(logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] b = {a[ADDR_W-1:LINE_OFF], {LINE_OFF{1'b0}}};
        return {mem_beat(b + 32'd8), mem_beat(b)};
    endfunction

    task automatic chk(string r, string what, logic ok, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    // Reference monitor, every clock
    always @(negedge clk) if (!rst) begin
        if (fill_valid) begin
            fill_cnt++;
            chk("R4", "fill without cacheable response", fetch_valid && out_cache, {fetch_valid, out_cache}, 2'b11);
            chk("R4", "fill data", fill_data == mem_line(fill_addr), fill_data, mem_line(fill_addr));
            chk("R4", "fill addr", fill_addr == {out_addr[ADDR_W-1:LINE_OFF], {LINE_OFF{1'b0}}},
                fill_addr, {out_addr[ADDR_W-1:LINE_OFF], {LINE_OFF{1'b0}}});
        end
        if (fetch_valid) begin
            chk("R6", "response with no fetch outstanding", outstanding, outstanding, 1);
            chk("R3", "fetch data", fetch_data == mem_line(out_addr), fetch_data, mem_line(out_addr));
            chk("R4", "fill presence follows cacheable", fill_valid == out_cache, fill_valid, out_cache);
            outstanding = 1'b0;
            resp_cnt++;
            resp_time = cyc;
        end
        if (bus_req) begin
            bus_cnt++;
            chk("R2", "burst address", bus_addr == {out_addr[ADDR_W-1:LINE_OFF], {LINE_OFF{1'b0}}},
                bus_addr, {out_addr[ADDR_W-1:LINE_OFF], {LINE_OFF{1'b0}}});
        end
    end

    // Bus responder: four ascending beats per request, optional idle gaps
    initial begin
        logic [ADDR_W-1:0] base;
        forever begin
            @(negedge clk);
            while (!rst && bus_req) begin
                base = bus_addr;
                for (int k = 0; k < BURST_BEATS; k++) begin
                    for (int w = 0; w < gap; w++) begin
                        bus_beat_valid = 1'b0;
                        @(negedge clk);
                    end
                    bus_beat_valid = 1'b1;
                    bus_beat_data  = mem_beat(base + 32'(k * BEAT_BYTES));
                    @(negedge clk);
                end
                bus_beat_valid = 1'b0;
            end
        end
    end

    task automatic issue(logic [ADDR_W-1:0] a, logic c);
        out_addr = a; out_cache = c; outstanding = 1'b1;
        t_issue = cyc; b_issue = bus_cnt; r_issue = resp_cnt; f_issue = fill_cnt;
        fetch_req = 1'b1; fetch_addr = a; fetch_cacheable = c;
        @(negedge clk); #1;
        fetch_req = 1'b0;
    endtask

    task automatic await(string r, int exp_lat, int exp_bus);
        int n = 0;
        while (resp_cnt == r_issue && n < 300) begin
            @(negedge clk); #1; n++;
        end
        chk(r, "response latency", (resp_cnt != r_issue) && (resp_time - t_issue == exp_lat),
            resp_time - t_issue, exp_lat);
        chk(r, "bus requests", bus_cnt - b_issue == exp_bus, bus_cnt - b_issue, exp_bus);
    endtask

    task automatic snoop_on(logic [ADDR_W-1:0] a, logic s);
        snoop_valid = 1'b1; snoop_addr = a; snoop_src = s;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: idle outputs after reset
        chk("R1", "outputs after reset", !fetch_valid && !fill_valid && !bus_req,
            {fetch_valid, fill_valid, bus_req}, 0);
        // R1 R2 R3 R4: first fetch misses, cacheable line filled
        issue(32'h1000, 1'b1); await("R1", 3, 1);
        chk("R4", "fill count cacheable miss", fill_cnt - f_issue == 1, fill_cnt - f_issue, 1);
        // R5 R12 R7: fetch during prefetch waits and is served from new block
        issue(32'h1010, 1'b1); await("R12", 2, 0);
        chk("R7", "fill on cacheable hit", fill_cnt - f_issue == 1, fill_cnt - f_issue, 1);
        idle(4);
        // R7: block moved out, same line misses again
        issue(32'h1010, 1'b1); await("R7", 3, 1);
        idle(8);
        // R6 R8: non-cacheable hits, no fill, block kept
        issue(32'h1024, 1'b0); await("R6", 1, 0);
        issue(32'h1028, 1'b0); await("R8", 1, 0);
        chk("R8", "no fill on non-cacheable hit", fill_cnt - f_issue == 0, fill_cnt - f_issue, 0);
        // R10: unrelated snoop leaves block valid
        snoop_on(32'h1030, 1'b0); idle(1); snoop_valid = 1'b0;
        issue(32'h1020, 1'b0); await("R10", 1, 0);
        // R9: inquire snoop invalidates
        snoop_on(32'h102C, 1'b1); idle(1); snoop_valid = 1'b0;
        issue(32'h1024, 1'b0); await("R9", 3, 1);
        chk("R4", "no fill on non-cacheable miss", fill_cnt - f_issue == 0, fill_cnt - f_issue, 0);
        idle(8);
        // R9: data-side snoop invalidates
        snoop_on(32'h1038, 1'b0); idle(1); snoop_valid = 1'b0;
        issue(32'h1030, 1'b0); await("R9", 3, 1);
        idle(8);
        // R13: fetch and snoop to the same block in one cycle
        snoop_on(32'h1044, 1'b0); issue(32'h1040, 1'b1); snoop_valid = 1'b0;
        await("R13", 3, 1);
        idle(8);
        // R11: snoop to block in flight
        issue(32'h2000, 1'b1); await("R11", 3, 1);
        snoop_on(32'h2010, 1'b0); idle(1); snoop_valid = 1'b0;
        idle(6);
        issue(32'h2010, 1'b0); await("R11", 3, 1);
        idle(8);
        // R11 R12: waiting fetch whose target is snooped goes to the bus
        issue(32'h3000, 1'b1); await("R11", 3, 1);
        snoop_on(32'h3010, 1'b1); issue(32'h3010, 1'b1); snoop_valid = 1'b0;
        await("R12", 4, 1);
        idle(8);
        // R11: snoop in the same cycle as the last beat
        issue(32'h4000, 1'b0);
        idle(3);
        snoop_on(32'h4018, 1'b0); idle(1); snoop_valid = 1'b0;
        await("R3", 3, 1);
        idle(6);
        issue(32'h4010, 1'b0); await("R11", 3, 1);
        idle(8);
        // R3 R12: beats with idle gaps
        gap = 2;
        issue(32'h5000, 1'b1); await("R3", 7, 1);
        issue(32'h5010, 1'b0); await("R12", 6, 0);
        idle(12);
        gap = 0;
        // R5: block kept after non-cacheable pending hit
        issue(32'h5018, 1'b0); await("R5", 1, 0);
        // R12: waiting fetch for another line starts a new burst
        issue(32'h6000, 1'b1); await("R2", 3, 1);
        issue(32'h7000, 1'b1); await("R12", 4, 1);
        idle(8);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule